// File: doc/BRIEF.md
# Fractional UART Baud Rate Generator

This block supplies the timing for a UART. It runs free from the peripheral clock and produces a clock-enable strobe at sixteen times the bit rate. The rate is set by a divisor with a 16-bit whole part and a 6-bit fraction counted in 1/64 steps. Each strobe period lasts either the whole part or the whole part plus one clock. A 6-bit accumulator chooses which periods get the extra clock, so that over 64 periods the average rate matches the fractional divisor exactly. A second counter divides the strobe by sixteen and gives one tick per transmitted bit. A separate 8-bit down-counter produces a strobe that sets the pulse width of a low-power infrared encoder.

Software computes the divisor as clock / (16 × baud). The fraction is rounded as trunc(fraction × 64 + 0.5), so a clock at least sixteen times the fastest baud rate is enough. The divisor values are placed on the inputs and take effect only when the update input is pulsed. That pulse also restarts every counter. Dropping the enable input stops and clears the counters. Raising it again restarts them from a clean phase.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset all three strobes are low, and they stay low until an update pulse loads nonzero divisors.
- R2: An update pulse sampled at a clock edge loads the whole part, the fraction and the infrared divisor, and restarts all counters. The first x16 strobe is high in the cycle after the W-th edge that follows the update edge, where W is the whole part.
- R3: Each x16 strobe pulse is one clock high, and consecutive pulses are W or W+1 clocks apart.
- R4: Counting from the update edge, the 64th x16 pulse ends exactly 64×W + F clocks later, where F is the fraction (0..63).
- R5: With fraction 0, every x16 period is exactly W clocks.
- R6: The k-th x16 pulse after a restart occurs k×W + floor(k×F/64) clocks after the restart edge.
- R7: A whole part of 0 keeps the x16 strobe and the bit tick low.
- R8: The bit tick is high together with every 16th x16 pulse counted from a restart (the 16th, 32nd, ...), and at no other time.
- R9: With infrared divisor L ≠ 0, the infrared strobe is high for one clock every L clocks, and first L clocks after the restart edge. With L = 0 it stays low.
- R10: While enable is low, all strobes are low. The edge after enable returns high starts a new phase, timed as in R2 and R6 from the last edge at which enable was low.
- R11: Divisor inputs that change without an update pulse have no effect on any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low clears all counters |
| update | input | 1 | One-cycle load and restart pulse |
| intDiv | input | 16 | Whole part of the x16 divisor |
| fracDiv | input | 6 | Fraction of the divisor in 1/64 steps |
| lpDiv | input | 8 | Infrared low-power strobe divisor, 0 disables |
| baud16Tick | output | 1 | One-clock strobe at sixteen times the bit rate |
| bitTick | output | 1 | One-clock strobe once per bit (every 16th x16 strobe) |
| lpTick | output | 1 | One-clock infrared low-power timing strobe |

## Verification
The hardest thing to observe is the exact spread of the stretched periods. A wrong accumulator width, or a stretch that lands one period early, still gives nearly the right average rate. It shows only when every pulse position is compared over a full 64-period cycle. The stimulus therefore reloads the generator many times with random whole parts and fractions, and with odd fractions such as 1 and 63. After each reload it compares every clock against the closed-form pulse times k×W + floor(k×F/64). In some runs the divisor inputs are scrambled after the load. Other runs drop enable in the middle of a phase, to show that the phase restarts cleanly.

// File: rtl/baud_pkg.sv
package baud_pkg;
  // strobes from the control unit to the counting datapaths
  typedef struct packed {
    logic clear;    // restart all counters this edge
    logic runMain;  // x16 divider may count
    logic runLp;    // infrared divider may count
  } ctlStrobes_t;
endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int LP_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              update,
  input  logic [INT_W-1:0]  intDiv,
  input  logic [FRAC_W-1:0] fracDiv,
  input  logic [LP_W-1:0]   lpDiv,
  output logic [INT_W-1:0]  activeInt,
  output logic [FRAC_W-1:0] activeFrac,
  output logic [LP_W-1:0]   lpReload,
  output ctlStrobes_t       ctl
);
  logic [LP_W-1:0] activeLp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeInt  <= '0;
      activeFrac <= '0;
      activeLp   <= '0;
    end else if (update) begin
      activeInt  <= intDiv;
      activeFrac <= fracDiv;
      activeLp   <= lpDiv;
    end
  end

  // value the infrared counter reloads from, including the one being loaded now
  assign lpReload = update ? lpDiv : activeLp;

  always_comb begin
    ctl.clear   = update || !enable;
    ctl.runMain = enable && (activeInt != '0);
    ctl.runLp   = enable && (activeLp != '0);
  end

  // load only on the update pulse
  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    update |=> (activeInt == $past(intDiv)) && (activeFrac == $past(fracDiv)));
  // divisors hold without update
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !update |=> $stable(activeInt) && $stable(activeFrac) && $stable(activeLp));
endmodule

// File: rtl/baud_datapath.sv
module baud_datapath
  import baud_pkg::*;
#(
  parameter int INT_W   = 16,
  parameter int FRAC_W  = 6,
  parameter int BIT_DIV = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [INT_W-1:0]  activeInt,
  input  logic [FRAC_W-1:0] activeFrac,
  output logic              baud16Tick,
  output logic              bitTick
);
  localparam int BIT_W = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BIT_DIV - 1);

  logic [INT_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   accSum;
  logic              stretch;
  logic [INT_W-1:0]  lastIdx;
  logic              periodEnd;
  logic [BIT_W-1:0]  bitCnt;

  always_comb begin
    accSum    = {1'b0, acc} + {1'b0, activeFrac};
    stretch   = accSum[FRAC_W];
    // a stretched period is activeInt+1 clocks long, so its last index is activeInt
    lastIdx   = stretch ? activeInt : activeInt - 1'b1;
    periodEnd = ctl.runMain && (cnt == lastIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt        <= '0;
      acc        <= '0;
      baud16Tick <= 1'b0;
    end else if (ctl.clear) begin
      cnt        <= '0;
      acc        <= '0;
      baud16Tick <= 1'b0;
    end else if (ctl.runMain) begin
      baud16Tick <= periodEnd;
      if (periodEnd) begin
        cnt <= '0;
        acc <= accSum[FRAC_W-1:0];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      baud16Tick <= 1'b0;
    end
  end

  // per-bit divider; a power-of-two ratio wraps naturally
  generate
    if ((1 << BIT_W) == BIT_DIV) begin : gPow2
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          bitCnt <= '0;
        else if (ctl.clear) bitCnt <= '0;
        else if (baud16Tick) bitCnt <= bitCnt + 1'b1;
      end
    end else begin : gAny
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          bitCnt <= '0;
        else if (ctl.clear) bitCnt <= '0;
        else if (baud16Tick) bitCnt <= (bitCnt == BIT_LAST) ? '0 : bitCnt + 1'b1;
      end
    end
  endgenerate

  assign bitTick = baud16Tick && (bitCnt == BIT_LAST);

  // count never runs past the current period's end
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.runMain && !ctl.clear) |-> (cnt <= lastIdx));
  // no strobe without a legal running divisor
  assert_zero_int_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
    baud16Tick |-> $past(ctl.runMain));
  // the accumulator moves only at a period end
  assert_acc_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.clear && !periodEnd) |=> $stable(acc));
  // bit counter advances only on a strobe
  assert_bit_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.clear && !baud16Tick) |=> $stable(bitCnt));
endmodule

// File: rtl/irda_lp_div.sv
module irda_lp_div
  import baud_pkg::*;
#(
  parameter int LP_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobes_t     ctl,
  input  logic [LP_W-1:0] lpReload,
  output logic            lpTick
);
  logic [LP_W-1:0] lpCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lpCnt  <= '0;
      lpTick <= 1'b0;
    end else if (ctl.clear) begin
      lpCnt  <= lpReload - 1'b1;
      lpTick <= 1'b0;
    end else if (ctl.runLp) begin
      if (lpCnt == '0) begin
        lpCnt  <= lpReload - 1'b1;
        lpTick <= 1'b1;
      end else begin
        lpCnt  <= lpCnt - 1'b1;
        lpTick <= 1'b0;
      end
    end else begin
      lpTick <= 1'b0;
    end
  end

  // a zero divisor or low enable keeps the strobe off
  assert_lp_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    lpTick |-> $past(ctl.runLp));
  // the counter never exceeds its reload value while running
  assert_lp_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.runLp && !ctl.clear) |-> (lpCnt < lpReload));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import baud_pkg::*;
#(
  parameter int INT_W   = 16,
  parameter int FRAC_W  = 6,
  parameter int LP_W    = 8,
  parameter int BIT_DIV = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              update,
  input  logic [INT_W-1:0]  intDiv,
  input  logic [FRAC_W-1:0] fracDiv,
  input  logic [LP_W-1:0]   lpDiv,
  output logic              baud16Tick,
  output logic              bitTick,
  output logic              lpTick
);
  ctlStrobes_t       ctl;
  logic [INT_W-1:0]  activeInt;
  logic [FRAC_W-1:0] activeFrac;
  logic [LP_W-1:0]   lpReload;

  baud_ctrl #(.INT_W(INT_W), .FRAC_W(FRAC_W), .LP_W(LP_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .update(update),
    .intDiv(intDiv), .fracDiv(fracDiv), .lpDiv(lpDiv),
    .activeInt(activeInt), .activeFrac(activeFrac), .lpReload(lpReload),
    .ctl(ctl));

  baud_datapath #(.INT_W(INT_W), .FRAC_W(FRAC_W), .BIT_DIV(BIT_DIV)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .activeInt(activeInt), .activeFrac(activeFrac),
    .baud16Tick(baud16Tick), .bitTick(bitTick));

  irda_lp_div #(.LP_W(LP_W)) uLp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .lpReload(lpReload), .lpTick(lpTick));

  // reset leaves every strobe low
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> !baud16Tick && !lpTick);
endmodule

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic update = 1'b0;
  logic [15:0] intDiv = '0;
  logic [5:0]  fracDiv = '0;
  logic [7:0]  lpDiv = '0;
  logic baud16Tick, bitTick, lpTick;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_baud_gen u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .update(update),
    .intDiv(intDiv), .fracDiv(fracDiv), .lpDiv(lpDiv),
    .baud16Tick(baud16Tick), .bitTick(bitTick), .lpTick(lpTick));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // k-th x16 pulse time after a restart (R6)
  function automatic longint pulseTime(longint k, longint w, longint f);
    return k * w + (k * f) / 64;
  endfunction

  // divisor from clock and baud: fraction rounded as trunc(frac*64+0.5)
  function automatic longint divisor64(longint clkHz, longint baud);
    return ((clkHz * 128) / (16 * baud) + 1) / 2;
  endfunction

  task automatic loadDiv(input int w, input int f, input int l);
    @(negedge clk);
    intDiv = 16'(w); fracDiv = 6'(f); lpDiv = 8'(l); update = 1'b1;
    @(negedge clk);
    update = 1'b0;
  endtask

  // called at the negedge right after the restart edge (t = 0)
  task automatic runWindow(input int w, input int f, input int l, input int cycles,
                           input bit scramble, input string tag);
    longint k = 1;
    longint nextT = (w == 0) ? -1 : pulseTime(1, w, f);
    longint seen = 0;
    longint lastT = -1;
    string baudReq;
    for (int t = 0; t <= cycles; t++) begin
      bit expBaud = (w != 0) && (t == nextT);
      bit expBit  = expBaud && (k % 16 == 0);
      bit expLp   = (l != 0) && (t > 0) && (t % l == 0);
      if (tag != "")      baudReq = tag;
      else if (w == 0)    baudReq = "R7";
      else if (k == 1)    baudReq = "R2";
      else if (f == 0)    baudReq = "R5";
      else                baudReq = "R6";
      check(baud16Tick == expBaud, baudReq, baud16Tick, expBaud);
      check(bitTick == expBit, (tag != "") ? tag : "R8", bitTick, expBit);
      check(lpTick == expLp, (tag != "") ? tag : "R9", lpTick, expLp);
      if (baud16Tick) begin
        seen++;
        if (lastT >= 0)
          check((t - lastT == w) || (t - lastT == w + 1), "R3", t - lastT, w);
        lastT = t;
        if (seen == 64) check(t == 64 * w + f, "R4", t, 64 * w + f);
      end
      if (expBaud) begin
        k++;
        nextT = pulseTime(k, w, f);
      end
      if (scramble) begin
        intDiv = 16'($urandom); fracDiv = 6'($urandom); lpDiv = 8'($urandom);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    longint d;
    void'($urandom(32'd2024));
    // R1: reset, with divisors present but never loaded
    intDiv = 16'd3; fracDiv = 6'd5; lpDiv = 8'd2; enable = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      check(!baud16Tick && !bitTick && !lpTick, "R1",
            {baud16Tick, bitTick, lpTick}, 0);
    end

    // directed corners
    loadDiv(5, 0, 3);   runWindow(5, 0, 3, 64 * 5 + 20, 1'b0, "");
    loadDiv(4, 1, 0);   runWindow(4, 1, 0, 64 * 5 + 20, 1'b0, "");
    loadDiv(3, 63, 1);  runWindow(3, 63, 1, 64 * 4 + 20, 1'b0, "");
    loadDiv(1, 32, 7);  runWindow(1, 32, 7, 64 * 2 + 20, 1'b0, "");
    loadDiv(1, 0, 255); runWindow(1, 0, 255, 300, 1'b0, "");
    loadDiv(0, 17, 4);  runWindow(0, 17, 4, 200, 1'b0, "R7");
    loadDiv(65535, 0, 0); runWindow(65535, 0, 0, 65540, 1'b0, "R2");

    // rounding: 50 MHz clock at 115200 baud
    d = divisor64(50000000, 115200);
    loadDiv(int'(d >> 6), int'(d & 63), 9);
    runWindow(int'(d >> 6), int'(d & 63), 9, 64 * 28 + 10, 1'b0, "");

    // R11: inputs scrambled after the load
    loadDiv(7, 45, 5);  runWindow(7, 45, 5, 64 * 8 + 10, 1'b1, "R11");

    // R10: enable dropped mid-phase, then raised
    loadDiv(6, 21, 4);  runWindow(6, 21, 4, 37, 1'b0, "");
    enable = 1'b0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      check(!baud16Tick && !bitTick && !lpTick, "R10",
            {baud16Tick, bitTick, lpTick}, 0);
    end
    enable = 1'b1;
    runWindow(6, 21, 4, 64 * 7 + 10, 1'b0, "R10");

    // random loads
    for (int n = 0; n < 14; n++) begin
      int w = 1 + int'($urandom % 30);
      int f = int'($urandom % 64);
      int l = int'($urandom % 20);
      loadDiv(w, f, l);
      runWindow(w, f, l, 64 * (w + 1) + 5, 1'b0, "");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule